// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the control pins of an SDRAM device and never drives them. On every rising clock edge it decodes chip select, row strobe, column strobe and write enable into one command. It keeps a simplified picture of the device in one of eight tracked states and raises a flag when the command arriving in the current state is not allowed there. The timed states are write recovery, write recovery with auto-precharge, precharging, refreshing and mode register access. Each one is left after a programmable number of cycles, counted by a single shared down-counter.

The meaning of a command depends on the state it arrives in. A quiet cycle in write recovery returns the device to row active. The same quiet cycle in write recovery with auto-precharge sends it to precharging instead. A read or write taken during write recovery picks its auto-precharge behaviour from address bit A10. The clock-enable pin gates evaluation: a command is judged only when clock enable was high at the previous edge. An idle device with clock enable low is tracked as powered down until clock enable returns high.

All outputs are registered. The decoded command, the offending command and its state all appear one clock after the edge that sampled the pins.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With csN high the command is deselect (code 0) whatever the other pins are. With csN low, {rasN,casN,weN} decodes as follows: 111 NOP (1), 110 burst stop (2), 101 read (3), 100 write (4), 011 activate (5), 010 precharge (6), 001 refresh (7), 000 mode register set (8). cmdOut shows the code of the sample taken at the previous edge.
- R2: State codes are idle 0, row active 1, write recovering 2, write recovering with auto-precharge 3, precharging 4, refreshing 5, mode register accessing 6, powered down 7. Reset gives state 0, cmdOut 0, no flag and a cleared counter. The first edge after reset only samples clock enable and does not judge the command.
- R3: In idle, deselect, NOP, burst stop and precharge keep the state. Activate goes to row active, refresh goes to refreshing, and mode register set goes to mode register accessing. Read and write are illegal.
- R4: In row active, deselect, NOP and burst stop keep the state. Precharge goes to precharging. A read goes to precharging when A10 is 1 and stays in row active when A10 is 0. A write goes to write recovering with auto-precharge when A10 is 1 and to write recovering when A10 is 0. Activate, refresh and mode register set are illegal.
- R5: Write recovering lasts T_DPL cycles and then goes to row active. A read or write in this state is legal and behaves as in R4, and a write restarts the recovery time. Activate, precharge, refresh and mode register set are illegal.
- R6: Write recovering with auto-precharge lasts T_DPL cycles and then goes to precharging. Every command other than deselect, NOP and burst stop is illegal.
- R7: Precharging lasts T_RP cycles and then goes to idle. Every command other than deselect, NOP and burst stop is illegal.
- R8: Refreshing lasts T_RC cycles and then goes to idle. Every command other than deselect, NOP and burst stop is illegal.
- R9: Mode register accessing lasts T_MRD cycles and then goes to idle. Every command other than deselect, NOP and burst stop is illegal.
- R10: A command is judged only when cke was high at the previous edge, and an unjudged command never raises the flag. From idle, a cycle with cke low goes to powered down if the command was either unjudged or one that keeps idle. Powered down holds while cke is low and returns to idle at the first edge with cke high. Timers keep running while commands are gated.
- R11: An illegal command raises illegalPulse for one cycle per offending edge. illegalCmd and illegalState then show that command and the state it arrived in. The command itself does not change the state, so a timer that expires at that same edge still moves the state on.
- R12: When a legal command that changes the state arrives at the same edge a timer expires, the command's transition wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the pins |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin of the device |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit choosing auto-precharge |
| cmdOut | output | 4 | Decoded command of the last sample |
| stateOut | output | 3 | Tracked device state |
| illegalPulse | output | 1 | One-cycle flag for an illegal command |
| illegalCmd | output | 4 | Last illegal command |
| illegalState | output | 3 | State in which that command arrived |

## Verification
The clash that matters is a timer running out at the same edge a command arrives. The command may be a legal one that moves the state, which must win (R12), or an illegal one, which must not hold back the timed exit (R11). The bench steps into each timed state and inserts zero to three quiet cycles before each probe command. This places the probe before, on and after the expiry edge. The state and flag are then compared every cycle with a behavioural model that counts the remaining cycles itself. A second clash comes from clock enable falling in idle on the same edge as a command. That edge both judges the command and decides power-down entry.

// File: rtl/sdram_mon_pkg.sv
`timescale 1ns/1ps
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ROW     = 3'd1,
    ST_WREC    = 3'd2,
    ST_WREC_AP = 3'd3,
    ST_PRECH   = 3'd4,
    ST_REFR    = 3'd5,
    ST_MRACC   = 3'd6,
    ST_PWRDN   = 3'd7
  } state_e;

  typedef enum logic [1:0] {
    TSEL_DPL = 2'd0,
    TSEL_RP  = 2'd1,
    TSEL_RC  = 2'd2,
    TSEL_MRD = 2'd3
  } tsel_e;

  typedef struct packed {
    logic  load;
    tsel_e sel;
    logic  flag;
  } strobe_t;

endpackage

// File: rtl/sdram_mon_datapath.sv
`timescale 1ns/1ps
module sdram_mon_datapath
  import sdram_mon_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RP  = 3,
  parameter int T_RC  = 4,
  parameter int T_MRD = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cke,
  input  logic    csN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  input  strobe_t stb,
  input  state_e  stateIn,
  output cmd_e    cmd,
  output logic    ckePrev,
  output logic    timerZero,
  output cmd_e    cmdOut,
  output logic    illegalPulse,
  output cmd_e    illegalCmd,
  output state_e  illegalState
);

  localparam int MAX_AB = (T_DPL > T_RP) ? T_DPL : T_RP;
  localparam int MAX_CD = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // pin decode: chip select dominates the other three strobes
  always_comb begin
    if (csN) begin
      cmd = CMD_DESL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

  always_comb begin
    case (stb.sel)
      TSEL_DPL: loadVal = CNT_W'(T_DPL - 1);
      TSEL_RP:  loadVal = CNT_W'(T_RP - 1);
      TSEL_RC:  loadVal = CNT_W'(T_RC - 1);
      default:  loadVal = CNT_W'(T_MRD - 1);
    endcase
  end

  // shared interval counter: loaded on entry, exit strobe at zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign timerZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev      <= 1'b0;
      cmdOut       <= CMD_DESL;
      illegalPulse <= 1'b0;
      illegalCmd   <= CMD_DESL;
      illegalState <= ST_IDLE;
    end else begin
      ckePrev      <= cke;
      cmdOut       <= cmd;
      illegalPulse <= stb.flag;
      if (stb.flag) begin
        illegalCmd   <= cmd;
        illegalState <= stateIn;
      end
    end
  end

  AST_GATED_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !ckePrev |=> !illegalPulse) else $error("gated command flagged"); // R10

endmodule

// File: rtl/sdram_mon_control.sv
`timescale 1ns/1ps
module sdram_mon_control
  import sdram_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cmd_e    cmd,
  input  logic    a10,
  input  logic    cke,
  input  logic    evalEn,
  input  logic    timerZero,
  output state_e  state,
  output strobe_t stb
);

  state_e nextState;
  logic   legal;
  logic   nopCls;

  always_comb begin
    nextState = state;
    legal     = 1'b1;
    stb.load  = 1'b0;
    stb.sel   = TSEL_DPL;
    nopCls    = (cmd == CMD_DESL) || (cmd == CMD_NOP) || (cmd == CMD_BST);
    case (state)
      ST_IDLE: begin
        if (evalEn) begin
          case (cmd)
            CMD_ACT: nextState = ST_ROW;
            CMD_REF: begin
              nextState = ST_REFR;
              stb.load  = 1'b1;
              stb.sel   = TSEL_RC;
            end
            CMD_MRS: begin
              nextState = ST_MRACC;
              stb.load  = 1'b1;
              stb.sel   = TSEL_MRD;
            end
            CMD_READ, CMD_WRITE: legal = 1'b0;
            default: ;
          endcase
        end
        if (!cke && (!evalEn || nopCls || cmd == CMD_PRE)) begin
          nextState = ST_PWRDN;
        end
      end
      ST_ROW, ST_WREC: begin
        if (state == ST_WREC && timerZero) begin
          nextState = ST_ROW;
        end
        if (evalEn) begin
          case (cmd)
            CMD_READ: begin
              nextState = a10 ? ST_PRECH : ST_ROW;
              stb.load  = a10;
              stb.sel   = TSEL_RP;
            end
            CMD_WRITE: begin
              nextState = a10 ? ST_WREC_AP : ST_WREC;
              stb.load  = 1'b1;
              stb.sel   = TSEL_DPL;
            end
            CMD_PRE: begin
              if (state == ST_ROW) begin
                nextState = ST_PRECH;
                stb.load  = 1'b1;
                stb.sel   = TSEL_RP;
              end else begin
                legal = 1'b0;
              end
            end
            CMD_DESL, CMD_NOP, CMD_BST: ;
            default: legal = 1'b0;
          endcase
        end
      end
      ST_WREC_AP: begin
        if (timerZero) begin
          nextState = ST_PRECH;
          stb.load  = 1'b1;
          stb.sel   = TSEL_RP;
        end
        if (evalEn && !nopCls) legal = 1'b0;
      end
      ST_PRECH, ST_REFR, ST_MRACC: begin
        if (timerZero) nextState = ST_IDLE;
        if (evalEn && !nopCls) legal = 1'b0;
      end
      default: begin
        nextState = cke ? ST_IDLE : ST_PWRDN;
      end
    endcase
    stb.flag = evalEn && !legal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_PWRDN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRDN && $past(state) != ST_PWRDN) |-> $past(state) == ST_IDLE)
    else $error("power-down entered from a busy state"); // R10

  AST_WREC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ROW && $past(state) == ST_WREC) |-> ($past(timerZero) || $past(evalEn)))
    else $error("write recovery left early"); // R5

  AST_REFR_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFR && timerZero) |=> state == ST_IDLE)
    else $error("refresh did not end at zero"); // R8

  AST_MRACC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MRACC && timerZero) |=> state == ST_IDLE)
    else $error("mode access did not end at zero"); // R9

endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int T_DPL = 2,
  parameter int T_RP  = 3,
  parameter int T_RC  = 4,
  parameter int T_MRD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       a10,
  output logic [3:0] cmdOut,
  output logic [2:0] stateOut,
  output logic       illegalPulse,
  output logic [3:0] illegalCmd,
  output logic [2:0] illegalState
);

  cmd_e    cmd;
  cmd_e    cmdQ;
  cmd_e    illCmdQ;
  state_e  state;
  state_e  illStateQ;
  strobe_t stb;
  logic    ckePrev;
  logic    timerZero;

  sdram_mon_datapath #(
    .T_DPL(T_DPL), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .stb(stb), .stateIn(state), .cmd(cmd),
    .ckePrev(ckePrev), .timerZero(timerZero), .cmdOut(cmdQ),
    .illegalPulse(illegalPulse), .illegalCmd(illCmdQ),
    .illegalState(illStateQ)
  );

  sdram_mon_control u_ctl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .a10(a10), .cke(cke),
    .evalEn(ckePrev), .timerZero(timerZero), .state(state), .stb(stb)
  );

  assign cmdOut       = cmdQ;
  assign stateOut     = state;
  assign illegalCmd   = illCmdQ;
  assign illegalState = illStateQ;

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;

  localparam int T_DPL = 2;
  localparam int T_RP  = 3;
  localparam int T_RC  = 4;
  localparam int T_MRD = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, a10 = 1'b0;
  logic [3:0] cmdOut;
  logic [2:0] stateOut;
  logic       illegalPulse;
  logic [3:0] illegalCmd;
  logic [2:0] illegalState;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int mState = 0;
  int mCnt = 0;
  bit mCkePrev = 0;

  sdram_cmd_monitor #(.T_DPL(T_DPL), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .a10(a10), .cmdOut(cmdOut), .stateOut(stateOut),
    .illegalPulse(illegalPulse), .illegalCmd(illegalCmd), .illegalState(illegalState)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // allowed commands per state; codes as in R1/R2
  function automatic bit allowed(int s, int c);
    if (c <= 2) return 1;
    case (s)
      0: return (c >= 5);
      1: return (c == 3 || c == 4 || c == 6);
      2: return (c == 3 || c == 4);
      default: return 0;
    endcase
  endfunction

  function automatic string stateTag(int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic setPins(int c);
    if (c == 0) begin
      csN = 1; rasN = 0; casN = 0; weN = 0; // R1: cs high dominates
    end else begin
      csN = 0;
      case (c)
        1: {rasN, casN, weN} = 3'b111;
        2: {rasN, casN, weN} = 3'b110;
        3: {rasN, casN, weN} = 3'b101;
        4: {rasN, casN, weN} = 3'b100;
        5: {rasN, casN, weN} = 3'b011;
        6: {rasN, casN, weN} = 3'b010;
        7: {rasN, casN, weN} = 3'b001;
        default: {rasN, casN, weN} = 3'b000;
      endcase
    end
  endtask

  task automatic step(int c, bit av, bit kv);
    int s = mState;
    bit ev = mCkePrev;
    bit lg = allowed(mState, c);
    bit quiet = (c <= 2);
    bit timed = (s >= 2 && s <= 6);
    bit expire = timed && (mCnt == 1);
    int ns = s;
    int nc = timed ? mCnt - 1 : 0;
    bit eIll = 0;
    string tag;
    setPins(c);
    a10 = av;
    cke = kv;
    if (s == 7) begin
      ns = kv ? 0 : 7;
    end else begin
      if (expire) begin
        case (s)
          2: ns = 1;
          3: begin ns = 4; nc = T_RP; end
          default: ns = 0;
        endcase
      end
      if (ev && lg && !quiet) begin
        case (c)
          5: ns = 1;
          7: begin ns = 5; nc = T_RC; end
          8: begin ns = 6; nc = T_MRD; end
          6: if (s == 1) begin ns = 4; nc = T_RP; end
          3: if (av) begin ns = 4; nc = T_RP; end else ns = 1;
          default: begin ns = av ? 3 : 2; nc = T_DPL; end
        endcase
      end
      if (s == 0 && !kv && (!ev || (lg && (quiet || c == 6)))) ns = 7;
      eIll = ev && !lg;
    end
    if (s == 7 || !ev) tag = "R10";
    else if (expire && lg && !quiet) tag = "R12";
    else tag = stateTag(s);
    @(posedge clk);
    @(negedge clk);
    mState = ns;
    mCnt = nc;
    mCkePrev = kv;
    chk(stateOut == 3'(ns), tag, "next state", int'(stateOut), ns);
    chk(illegalPulse == eIll, tag, "illegal flag", int'(illegalPulse), int'(eIll));
    chk(cmdOut == 4'(c), "R1", "decoded command", int'(cmdOut), c);
    if (eIll) begin
      chk(illegalCmd == 4'(c), "R11", "flagged command copy", int'(illegalCmd), c);
      chk(illegalState == 3'(s), "R11", "flagged state copy", int'(illegalState), s);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 10; i++) step(1, 0, 1);
    step(6, 0, 1);
    for (int i = 0; i < 10; i++) step(1, 0, 1);
  endtask

  initial begin
    setPins(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stateOut == 3'd0, "R2", "reset state", int'(stateOut), 0);
    chk(illegalPulse == 1'b0, "R2", "reset flag", int'(illegalPulse), 0);
    chk(cmdOut == 4'd0, "R2", "reset command", int'(cmdOut), 0);
    rstN = 1;
    mState = 0; mCnt = 0; mCkePrev = 0;
    // R2: first edge after reset does not judge; a read here is not flagged
    step(3, 0, 1);
    step(1, 0, 1);

    // every command in every state, probe before/on/after timer expiry
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < 9; c++) begin
        for (int a = 0; a < 2; a++) begin
          for (int d = 0; d < 4; d++) begin
            case (t)
              1: step(5, 0, 1);
              2: begin step(5, 0, 1); step(4, 0, 1); end
              3: begin step(5, 0, 1); step(4, 1, 1); end
              4: begin step(5, 0, 1); step(6, 0, 1); end
              5: step(7, 0, 1);
              6: step(8, 0, 1);
              7: step(1, 0, 0);
              default: ;
            endcase
            for (int k = 0; k < d; k++) step(1, 0, (t == 7) ? 1'b0 : 1'b1);
            step(c, a[0], (t == 7) ? a[0] : 1'b1);
            drain();
          end
        end
      end
    end

    // R10: gated command in row active and in refreshing
    step(5, 0, 1);
    step(1, 0, 0);
    step(5, 0, 1);
    drain();
    step(7, 0, 1);
    step(1, 0, 0);
    step(8, 0, 0);
    step(8, 0, 1);
    drain();
    // R10: power-down entry on the same edge as a precharge in idle
    step(6, 0, 0);
    step(3, 0, 0);
    step(1, 0, 1);
    step(3, 0, 1);
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule